// File: doc/BRIEF.md
# Stream Route Lookup

This block chooses an egress port for each packet entering a small packet switch. It watches the handshake of one ingress stream and finds the first beat of every packet. From bits [31:0] of that beat it reads a 32-bit stream identifier. The identifier holds four bytes, from most to least significant: source network, source host, destination network, destination host. The block then looks up the destination and presents the chosen port index with a valid flag. The flag stays up until the switch's arbiter acknowledges the decision.

The lookup has two levels. The destination network byte is first compared with a programmable local network address. On a mismatch, a 256-entry table indexed by the destination network byte gives the port. On a match, the packet is for a host on this network, and a second 256-entry table indexed by the destination host byte gives the port. A settings bus writes both tables and the local address. Each write is one strobed cycle carrying a 16-bit address and a 32-bit data word. The block does not check that table entries are unique or consistent; software keeps them sensible.

Top module: `sid_fwd_lookup`

## Requirements
- R1: Out of reset `route_valid` is low, the local address is 0 and every table entry reads as port 0. A packet looked up before any write therefore gets port 0.
- R2: A beat is a packet's first beat when `in_tvalid` and `in_tready` are both high and no packet is in progress. That beat sets the in-progress state. A handshaken beat with `in_tlast` high clears it. Only first beats start a lookup, and a single-beat packet leaves the next beat as a first beat.
- R3: When the destination network byte (identifier bits [15:8]) differs from the local address, the port is the network table entry at that byte.
- R4: When the destination network byte equals the local address, the port is the host table entry at the destination host byte (identifier bits [7:0]).
- R5: A write to settings address 512 loads data bits [7:0] into the local address. The other data bits are ignored.
- R6: `route_valid` rises at the clock edge after the edge that accepts the first beat. `route_port` and `route_valid` then hold steady until a cycle with `route_ack` high. At the edge ending that cycle, `route_valid` falls unless a new lookup is captured.
- R7: While a decision is pending and not acknowledged, a first beat starts no lookup and is skipped. A first beat in the same cycle as `route_ack` is looked up, so `route_valid` stays high with the new port. `route_ack` with no pending decision has no effect.
- R8: Settings addresses 0..255 write the network table at offset (address), and 256..511 write the host table at offset (address-256). Only the low log2(outputs) data bits are stored. Writes to addresses above 512 change nothing.
- R9: When a table or local-address write and a lookup fall in the same cycle, the lookup uses the contents from before the write. The written value applies from the next lookup on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_stb | input | 1 | Settings write strobe |
| set_addr | input | SET_AW (16) | Settings address |
| set_data | input | SET_DW (32) | Settings data |
| in_tdata | input | BEAT_W (64) | Ingress beat data; identifier in [31:0] of the first beat |
| in_tvalid | input | 1 | Ingress beat valid |
| in_tready | input | 1 | Ingress beat ready, as seen on the stream |
| in_tlast | input | 1 | Ingress last beat of packet |
| route_port | output | clog2(NUM_OUT) (2) | Chosen egress port index |
| route_valid | output | 1 | Decision pending |
| route_ack | input | 1 | One-cycle acknowledge of the decision |

## Verification
Two pairs of events can share a cycle. The first is a settings write with a lookup, including a write to the very entry or local address the lookup uses. The second is an acknowledge with the next packet's first beat. The bench forces both on purpose: it pulses `set_stb` on the same negative edge that drives a first beat, and pulses `route_ack` on the edge that drives a new header. A random phase then overlaps writes, headers and acknowledges freely. A behavioural model compares every cycle. It applies writes after it evaluates the lookup, and it accepts a header only when nothing is pending or an acknowledge arrives with it, so it judges the old-versus-new contents and whether a decision was kept or dropped.

// File: rtl/sid_fwd_pkg.sv
package sid_fwd_pkg;
  localparam int FIELD_W   = 8;
  localparam int TBL_DEPTH = 1 << FIELD_W;
  localparam int NUM_TBL   = 2;
  localparam int TBL_NET   = 0;
  localparam int TBL_HOST  = 1;

  typedef struct packed {
    logic [FIELD_W-1:0] src_net;
    logic [FIELD_W-1:0] src_host;
    logic [FIELD_W-1:0] dst_net;
    logic [FIELD_W-1:0] dst_host;
  } sid_t;

  typedef enum logic [1:0] {
    TGT_NONE,
    TGT_NET,
    TGT_HOST,
    TGT_LOCAL
  } set_tgt_e;
endpackage

// File: rtl/sid_fwd_set_dec.sv
module sid_fwd_set_dec
  import sid_fwd_pkg::*;
#(
  parameter int SET_AW    = 16,
  parameter int SET_DW    = 32,
  parameter int PORT_W    = 2,
  parameter int NET_BASE  = 0,
  parameter int HOST_BASE = 256,
  parameter int LOCAL_REG = 512
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_stb,
  input  logic [SET_AW-1:0]  set_addr,
  input  logic [SET_DW-1:0]  set_data,
  output logic               net_we,
  output logic               host_we,
  output logic [FIELD_W-1:0] wr_idx,
  output logic [PORT_W-1:0]  wr_port,
  output logic [FIELD_W-1:0] local_addr
);
  localparam logic [SET_AW-1:0] NET_A   = SET_AW'(NET_BASE);
  localparam logic [SET_AW-1:0] HOST_A  = SET_AW'(HOST_BASE);
  localparam logic [SET_AW-1:0] LOCAL_A = SET_AW'(LOCAL_REG);
  localparam logic [SET_AW-1:0] SPAN    = SET_AW'(TBL_DEPTH);

  logic [SET_AW-1:0] net_off;
  logic [SET_AW-1:0] host_off;
  set_tgt_e          tgt;
  logic              unused_set_bits;

  assign net_off  = set_addr - NET_A;
  assign host_off = set_addr - HOST_A;

  always_comb begin
    tgt = TGT_NONE;
    if (set_stb) begin
      if (set_addr == LOCAL_A)  tgt = TGT_LOCAL;
      else if (host_off < SPAN) tgt = TGT_HOST;
      else if (net_off < SPAN)  tgt = TGT_NET;
    end
  end

  assign net_we  = (tgt == TGT_NET);
  assign host_we = (tgt == TGT_HOST);
  assign wr_idx  = (tgt == TGT_HOST) ? host_off[FIELD_W-1:0] : net_off[FIELD_W-1:0];
  assign wr_port = set_data[PORT_W-1:0];
  assign unused_set_bits = ^set_data[SET_DW-1:FIELD_W];

  always_ff @(posedge clk) begin
    if (rst)                    local_addr <= '0;
    else if (tgt == TGT_LOCAL)  local_addr <= set_data[FIELD_W-1:0];
  end

  p_local_load_r5: assert property (@(posedge clk) disable iff (rst)
    set_stb && set_addr == LOCAL_A |=> local_addr == $past(set_data[FIELD_W-1:0]))
    else $error("local address not loaded");

  p_high_addr_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    set_stb && set_addr > LOCAL_A |-> !net_we && !host_we)
    else $error("write above local register reached a table");

  p_local_kept_r8: assert property (@(posedge clk) disable iff (rst)
    !(set_stb && set_addr == LOCAL_A) |=> $stable(local_addr))
    else $error("local address changed without its write");
endmodule

// File: rtl/sid_fwd_table.sv
module sid_fwd_table #(
  parameter int IDX_W  = 8,
  parameter int PORT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [PORT_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  ridx,
  output logic [PORT_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [PORT_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  vld;
  logic [PORT_W-1:0] mem_q;
  logic              vld_q;

  // RAM body: write port and read-first registered read, no reset
  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) mem_q <= mem[ridx];
  end

  // written-once flags give the all-zero reset view
  always_ff @(posedge clk) begin
    if (rst)     vld <= '0;
    else if (we) vld[widx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)     vld_q <= 1'b0;
    else if (re) vld_q <= vld[ridx];
  end

  assign rdata = vld_q ? mem_q : '0;

  p_blank_entry_r1: assert property (@(posedge clk) disable iff (rst)
    re && !vld[ridx] |=> rdata == '0)
    else $error("unwritten entry read nonzero");

  p_read_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata))
    else $error("table output moved without a read");
endmodule

// File: rtl/sid_fwd_hdr_track.sv
module sid_fwd_hdr_track (
  input  logic clk,
  input  logic rst,
  input  logic beat_valid,
  input  logic beat_ready,
  input  logic beat_last,
  input  logic busy,
  input  logic release_i,
  output logic capture,
  output logic in_pkt
);
  logic fire;
  logic first_beat;

  assign fire       = beat_valid && beat_ready;
  assign first_beat = fire && !in_pkt;
  assign capture    = first_beat && (!busy || release_i);

  always_ff @(posedge clk) begin
    if (rst)       in_pkt <= 1'b0;
    else if (fire) in_pkt <= !beat_last;
  end

  p_last_clears_r2: assert property (@(posedge clk) disable iff (rst)
    beat_valid && beat_ready && beat_last |=> !in_pkt)
    else $error("last beat left packet open");

  p_first_opens_r2: assert property (@(posedge clk) disable iff (rst)
    beat_valid && beat_ready && !beat_last |=> in_pkt)
    else $error("non-last beat did not mark packet open");

  p_mid_no_lookup_r2: assert property (@(posedge clk) disable iff (rst)
    in_pkt |-> !capture)
    else $error("lookup started mid-packet");
endmodule

// File: rtl/sid_fwd_lookup.sv
module sid_fwd_lookup
  import sid_fwd_pkg::*;
#(
  parameter int NUM_OUT   = 4,
  parameter int BEAT_W    = 64,
  parameter int SET_AW    = 16,
  parameter int SET_DW    = 32,
  parameter int NET_BASE  = 0,
  parameter int HOST_BASE = 256,
  parameter int LOCAL_REG = 512,
  localparam int PORT_W   = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_stb,
  input  logic [SET_AW-1:0] set_addr,
  input  logic [SET_DW-1:0] set_data,
  input  logic [BEAT_W-1:0] in_tdata,
  input  logic              in_tvalid,
  input  logic              in_tready,
  input  logic              in_tlast,
  output logic [PORT_W-1:0] route_port,
  output logic              route_valid,
  input  logic              route_ack
);
  sid_t               sid;
  logic               capture;
  logic               in_pkt;
  logic               net_we;
  logic               host_we;
  logic [FIELD_W-1:0] wr_idx;
  logic [PORT_W-1:0]  wr_port;
  logic [FIELD_W-1:0] local_addr;
  logic               pick_host_q;
  logic               tbl_we   [NUM_TBL];
  logic [FIELD_W-1:0] tbl_ridx [NUM_TBL];
  logic [PORT_W-1:0]  tbl_rd   [NUM_TBL];
  logic               unused_hdr_bits;

  assign sid = in_tdata[31:0];

  generate
    if (BEAT_W > 32) begin : g_wide
      assign unused_hdr_bits = ^{in_tdata[BEAT_W-1:32], sid.src_net, sid.src_host, in_pkt};
    end else begin : g_narrow
      assign unused_hdr_bits = ^{sid.src_net, sid.src_host, in_pkt};
    end
  endgenerate

  sid_fwd_set_dec #(
    .SET_AW(SET_AW), .SET_DW(SET_DW), .PORT_W(PORT_W),
    .NET_BASE(NET_BASE), .HOST_BASE(HOST_BASE), .LOCAL_REG(LOCAL_REG)
  ) u_set_dec (
    .clk(clk), .rst(rst), .set_stb(set_stb), .set_addr(set_addr), .set_data(set_data),
    .net_we(net_we), .host_we(host_we), .wr_idx(wr_idx), .wr_port(wr_port),
    .local_addr(local_addr)
  );

  sid_fwd_hdr_track u_hdr (
    .clk(clk), .rst(rst), .beat_valid(in_tvalid), .beat_ready(in_tready),
    .beat_last(in_tlast), .busy(route_valid), .release_i(route_ack),
    .capture(capture), .in_pkt(in_pkt)
  );

  assign tbl_we[TBL_NET]    = net_we;
  assign tbl_we[TBL_HOST]   = host_we;
  assign tbl_ridx[TBL_NET]  = sid.dst_net;
  assign tbl_ridx[TBL_HOST] = sid.dst_host;

  // both levels are read together; the compare picks one a cycle later
  for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
    sid_fwd_table #(.IDX_W(FIELD_W), .PORT_W(PORT_W)) u_tbl (
      .clk(clk), .rst(rst), .we(tbl_we[t]), .widx(wr_idx), .wdata(wr_port),
      .re(capture), .ridx(tbl_ridx[t]), .rdata(tbl_rd[t])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)          pick_host_q <= 1'b0;
    else if (capture) pick_host_q <= (sid.dst_net == local_addr);
  end

  always_ff @(posedge clk) begin
    if (rst)            route_valid <= 1'b0;
    else if (capture)   route_valid <= 1'b1;
    else if (route_ack) route_valid <= 1'b0;
  end

  assign route_port = pick_host_q ? tbl_rd[TBL_HOST] : tbl_rd[TBL_NET];

  p_hold_until_ack_r6: assert property (@(posedge clk) disable iff (rst)
    route_valid && !route_ack |=> route_valid && $stable(route_port))
    else $error("decision changed before acknowledge");

  p_rise_after_beat_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(route_valid) |-> $past(in_tvalid && in_tready))
    else $error("decision without a handshaken beat");

  p_ack_drops_r7: assert property (@(posedge clk) disable iff (rst)
    route_valid && route_ack && !(in_tvalid && in_tready) |=> !route_valid)
    else $error("acknowledged decision still pending");
endmodule

// File: tb/sid_fwd_lookup_bench.sv
module sid_fwd_lookup_bench;
  localparam int NUM_OUT = 4;
  localparam int BEAT_W  = 64;
  localparam int PW      = 2;

  logic              clk = 1'b0;
  logic              rst;
  logic              set_stb;
  logic [15:0]       set_addr;
  logic [31:0]       set_data;
  logic [BEAT_W-1:0] in_tdata;
  logic              in_tvalid, in_tready, in_tlast;
  logic [PW-1:0]     route_port;
  logic              route_valid;
  logic              route_ack;

  always #10 clk = ~clk;

  sid_fwd_lookup #(.NUM_OUT(NUM_OUT), .BEAT_W(BEAT_W)) u_sid_fwd_lookup (
    .clk(clk), .rst(rst), .set_stb(set_stb), .set_addr(set_addr), .set_data(set_data),
    .in_tdata(in_tdata), .in_tvalid(in_tvalid), .in_tready(in_tready), .in_tlast(in_tlast),
    .route_port(route_port), .route_valid(route_valid), .route_ack(route_ack)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  int    cyc     = 0;
  string cur_req = "R1";
  bit    started = 0;
  bit    auto_ack = 0;
  int    vwait = 0;
  int    ack_dly = 0;

  // reference model state
  int m_net [256];
  int m_host[256];
  int m_local;
  bit m_inpkt, m_valid, m_host_sel;
  int m_port;

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin : ref_model
    bit fire, cap;
    int dn, dh, ad;
    if (rst) begin
      for (int i = 0; i < 256; i++) begin m_net[i] = 0; m_host[i] = 0; end
      m_local = 0; m_inpkt = 0; m_valid = 0; m_host_sel = 0; m_port = 0;
    end else begin
      fire = in_tvalid && in_tready;
      cap  = fire && !m_inpkt && (!m_valid || route_ack);
      if (m_valid && route_ack) m_valid = 0;
      if (cap) begin
        dn = int'(in_tdata[15:8]);
        dh = int'(in_tdata[7:0]);
        m_host_sel = (dn == m_local);
        m_port  = m_host_sel ? m_host[dh] : m_net[dn];
        m_valid = 1;
      end
      if (fire) m_inpkt = !in_tlast;
      // writes land after the lookup has read old contents
      if (set_stb) begin
        ad = int'(set_addr);
        if (ad < 256)       m_net[ad] = int'(set_data[1:0]);
        else if (ad < 512)  m_host[ad-256] = int'(set_data[1:0]);
        else if (ad == 512) m_local = int'(set_data[7:0]);
      end
    end
  end

  always @(negedge clk) begin
    if (started && !rst) begin
      check({cur_req, "/R6 valid"}, int'(route_valid), int'(m_valid));
      if (m_valid)
        check({m_host_sel ? "R4" : "R3", "/", cur_req, " port"}, int'(route_port), m_port);
    end
  end

  always @(negedge clk) begin
    if (auto_ack) begin
      route_ack = 1'b0;
      if (route_valid) begin
        if (vwait >= ack_dly) begin
          route_ack = 1'b1;
          vwait = 0;
          ack_dly = $urandom_range(0, 3);
        end else vwait++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL R6 watchdog: actual %0d cycles expected < 150000", cyc);
      finish_run();
    end
  end

  function automatic logic [31:0] mk(int dn, int dh);
    return {8'h5A, 8'hC3, 8'(dn), 8'(dh)};
  endfunction

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_tvalid = 1'b0; in_tready = 1'b0; in_tlast = 1'b0; set_stb = 1'b0;
    end
  endtask

  task automatic setw(int addr, logic [31:0] data);
    @(negedge clk);
    set_stb = 1'b1; set_addr = 16'(addr); set_data = data;
    @(negedge clk);
    set_stb = 1'b0;
  endtask

  task automatic beat(logic [31:0] sid, bit last);
    @(negedge clk);
    in_tvalid = 1'b1; in_tready = 1'b1; in_tlast = last;
    in_tdata = {$urandom, $urandom};
    in_tdata[31:0] = sid;
  endtask

  task automatic send_pkt(logic [31:0] sid, int nbeats, bit gap);
    for (int b = 0; b < nbeats; b++) begin
      bit done = 0;
      while (!done) begin
        @(negedge clk);
        in_tvalid = !gap || ($urandom_range(0, 3) != 0);
        in_tready = !gap || ($urandom_range(0, 3) != 0);
        in_tdata  = {$urandom, $urandom};
        if (b == 0) in_tdata[31:0] = sid;
        in_tlast  = (b == nbeats - 1);
        @(posedge clk);
        done = in_tvalid && in_tready;
      end
    end
    @(negedge clk);
    in_tvalid = 1'b0; in_tready = 1'b0; in_tlast = 1'b0;
  endtask

  initial begin
    int nets[6] = '{0, 1, 2, 3, 7, 9};
    rst = 1'b1; set_stb = 1'b0; set_addr = '0; set_data = '0;
    in_tdata = '0; in_tvalid = 1'b0; in_tready = 1'b0; in_tlast = 1'b0; route_ack = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    started = 1;
    check("R1 reset valid", int'(route_valid), 0);

    // R1: empty tables give port 0 on both levels
    cur_req = "R1"; auto_ack = 1;
    send_pkt(mk(5, 7), 3, 0);
    send_pkt(mk(0, 0), 1, 0);
    idle(6);

    // R8: table writes keep low bits only; stray addresses write nothing
    cur_req = "R8";
    setw(0, 32'hFFFF_FFF1);
    setw(1, 32'd3);
    setw(7, 32'hABCD_0002);
    setw(600, 32'd3);
    setw(768, 32'd3);
    setw(16'hFFFF, 32'd2);
    // R5: local address takes data bits [7:0]
    cur_req = "R5";
    setw(512, 32'h0000_0302);
    setw(256, 32'd0);
    setw(257, 32'd1);
    setw(258, 32'd2);
    setw(259, 32'd3);
    cur_req = "R8";
    send_pkt(mk(2, 88), 1, 0);
    send_pkt(mk(88, 0), 1, 0);
    send_pkt(mk(2, 0), 1, 0);
    idle(4);

    // R3 network level, R4 host level
    cur_req = "R3";
    send_pkt(mk(0, 9), 4, 1);
    send_pkt(mk(1, 2), 3, 1);
    send_pkt(mk(7, 1), 2, 0);
    cur_req = "R4";
    send_pkt(mk(2, 1), 3, 1);
    send_pkt(mk(2, 3), 1, 0);
    send_pkt(mk(2, 2), 5, 1);
    idle(6);

    // R2: back-to-back single beats, and a mid-packet beat shaped like a header
    cur_req = "R2";
    beat(mk(2, 3), 1);
    beat(mk(1, 0), 1);
    beat(mk(2, 1), 1);
    idle(8);
    beat(mk(7, 0), 0);
    beat(mk(2, 3), 1);
    idle(8);

    // R6 hold without ack, R7 skipped header and ack collisions
    auto_ack = 0; route_ack = 1'b0;
    cur_req = "R6";
    beat(mk(7, 0), 1);
    idle(6);
    cur_req = "R7";
    beat(mk(2, 3), 1);
    idle(3);
    @(negedge clk); route_ack = 1'b1;
    @(negedge clk); route_ack = 1'b0;
    idle(2);
    beat(mk(1, 0), 1);
    idle(3);
    beat(mk(2, 1), 1);
    route_ack = 1'b1;
    idle(1);
    route_ack = 1'b0;
    idle(3);
    @(negedge clk); route_ack = 1'b1;
    @(negedge clk); route_ack = 1'b0;
    idle(2);
    @(negedge clk); route_ack = 1'b1;
    @(negedge clk); route_ack = 1'b0;
    idle(2);
    auto_ack = 1;

    // R9: write and lookup in the same cycle see old contents
    cur_req = "R9";
    setw(9, 32'd1);
    idle(2);
    beat(mk(9, 0), 1);
    set_stb = 1'b1; set_addr = 16'd9; set_data = 32'd3;
    idle(6);
    send_pkt(mk(9, 0), 1, 0);
    idle(6);
    beat(mk(9, 2), 1);
    set_stb = 1'b1; set_addr = 16'd512; set_data = 32'd9;
    idle(6);
    send_pkt(mk(9, 2), 1, 0);
    idle(6);
    setw(512, 32'd2);

    // random overlap of packets, writes and acknowledges
    cur_req = "R2";
    fork
      begin
        for (int i = 0; i < 80; i++)
          send_pkt(mk(nets[$urandom_range(0, 5)], $urandom_range(0, 3)),
                   $urandom_range(1, 4), 1);
      end
      begin
        for (int i = 0; i < 40; i++) begin
          int kind;
          repeat ($urandom_range(3, 20)) @(negedge clk);
          kind = $urandom_range(0, 2);
          if (kind == 0)      setw(nets[$urandom_range(0, 5)], $urandom);
          else if (kind == 1) setw(256 + $urandom_range(0, 3), $urandom);
          else                setw(512, 32'(nets[$urandom_range(0, 4)]));
        end
      end
    join
    idle(10);
    finish_run();
  end
endmodule